// File: doc/BRIEF.md
# Overcurrent Alarm Filter and Counter

This block watches an external overcurrent alarm line and turns it into two signals for the rest of the chip: a level throttle request and a one-cycle interrupt pulse. The raw line is brought into the clock domain through a flop chain. The chosen polarity is applied on the way in, so inside the block a 1 always means "alarm". Each inactive-to-active transition of the synchronised alarm counts as one event. Events are counted, and an interrupt fires when the count reaches a programmed threshold. The counter then starts again from zero.

An inactivity filter clears a partly filled count when no event has arrived for a programmed number of clocks. Every event restarts that window. The throttle request follows the alarm level through a three-state machine: `THR_IDLE`, `THR_ACTIVE` and `THR_HOLD`. The transitions are:
- `IDLE→ACTIVE` when the alarm is seen.
- `ACTIVE→IDLE` when the alarm drops and no hold is programmed.
- `ACTIVE→HOLD` when the alarm drops and a hold is programmed.
- `HOLD→ACTIVE` when the alarm returns during the hold.
- `HOLD→IDLE` when the hold timer runs out.

The hold time is given in microseconds and is converted to clocks through the `CLK_PER_US` parameter.

Top module: `oc_alarm_monitor`

## Requirements
- R1: With `cfg_active_low`=1 a low level on `alarm_raw` is an alarm. With `cfg_active_low`=0 a high level is an alarm.
- R2: An alarm level present on `alarm_raw` before clock edge k raises `throttle_o` after edge k+2. A falling alarm with no hold programmed lowers it with the same latency.
- R3: With threshold N≥1, the Nth event since the counter last restarted raises `irq_o` for exactly one cycle, in the cycle after the event is detected. The count then restarts at zero.
- R4: A threshold of 0 or 1 raises an interrupt on every event.
- R5: With `cfg_irq_en`=0 no interrupt is raised. Throttling is unaffected and events are still counted.
- R6: With `cfg_filter`=F>0, when F clocks pass after an event with no further event, the count is cleared. Every event restarts this window.
- R7: With `cfg_filter`=0 the count is never cleared by inactivity.
- R8: After the alarm drops, `throttle_o` stays high for `cfg_hold_us`×`CLK_PER_US` further cycles. A value of 0 releases it at once.
- R9: An alarm that returns during the hold keeps `throttle_o` high without a gap.
- R10: While `rst_n` is low, `throttle_o` and `irq_o` are 0 and all counts and timers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_raw | input | 1 | Asynchronous overcurrent alarm line |
| cfg_active_low | input | 1 | 1: low level is an alarm |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_threshold | input | CNT_W | Events per interrupt (0 behaves as 1) |
| cfg_filter | input | FILT_W | Inactivity window in clocks, 0 disables |
| cfg_hold_us | input | HOLD_W | Throttle hold after deassertion, microseconds |
| throttle_o | output | 1 | Throttle request level |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
A wrong count shows up as an interrupt pulse one event early or late, or as a missing pulse. This is visible on `irq_o` the cycle after the offending event. A stale count left by a broken filter shows up on the first threshold crossing after the idle gap. A wrong state or hold timer value shows up on `throttle_o` as an early or late release, or as a gap between two alarms. The release edge moves by as many cycles as the timer is off. The bench therefore compares both outputs against a behavioural model on every clock. It also counts pulses and throttle-high cycles per scenario.

// File: rtl/oc_mon_pkg.sv
package oc_mon_pkg;
    typedef enum logic [1:0] {
        THR_IDLE   = 2'd0,
        THR_ACTIVE = 2'd1,
        THR_HOLD   = 2'd2
    } thr_state_e;
endpackage

// File: rtl/oc_sync.sv
// Synchroniser with polarity applied at the input; reports level and rising event.
module oc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic active_low,
    output logic lvl,
    output logic evt
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= raw ^ active_low;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], raw ^ active_low};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign lvl = chain[STAGES-1];
    assign evt = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/oc_event_counter.sv
// Event counter with threshold interrupt and inactivity clear.
module oc_event_counter #(
    parameter int CNT_W  = 8,
    parameter int FILT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic              irq_en,
    input  logic [CNT_W-1:0]  threshold,
    input  logic [FILT_W-1:0] filter,
    output logic              irq
);
    logic [CNT_W-1:0]  count;
    logic [FILT_W-1:0] idle_t;
    logic              hit;
    logic              expire;
    logic              filt_on;

    assign hit     = ({1'b0, count} + 1'b1) >= {1'b0, threshold};
    assign filt_on = (filter != '0);
    assign expire  = filt_on && (({1'b0, idle_t} + 1'b1) >= {1'b0, filter});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            idle_t <= '0;
            irq    <= 1'b0;
        end else if (evt) begin
            idle_t <= '0;
            irq    <= hit & irq_en;
            count  <= hit ? '0 : count + 1'b1;
        end else begin
            irq <= 1'b0;
            if (expire) begin
                count  <= '0;
                idle_t <= '0;
            end else if (filt_on) begin
                idle_t <= idle_t + 1'b1;
            end
        end
    end
endmodule

// File: rtl/oc_throttle_fsm.sv
// Throttle state machine with post-deassertion hold timer.
module oc_throttle_fsm
    import oc_mon_pkg::*;
#(
    parameter int HOLD_W     = 16,
    parameter int CLK_PER_US = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl,
    input  logic [HOLD_W-1:0] hold_us,
    output logic              throttle
);
    localparam int MUL_W = $clog2(CLK_PER_US + 1);
    localparam int TMR_W = HOLD_W + MUL_W;

    thr_state_e        state, state_nx;
    logic [TMR_W-1:0]  hold_cyc;
    logic [TMR_W-1:0]  tmr;

    assign hold_cyc = TMR_W'(hold_us) * TMR_W'(CLK_PER_US);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= THR_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            THR_IDLE:   if (lvl) state_nx = THR_ACTIVE;
            THR_ACTIVE: if (!lvl) state_nx = (hold_cyc == '0) ? THR_IDLE : THR_HOLD;
            THR_HOLD: begin
                if (lvl)              state_nx = THR_ACTIVE;
                else if (tmr == '0)   state_nx = THR_IDLE;
            end
            default:    state_nx = THR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr <= '0;
        end else if (state == THR_ACTIVE && !lvl && hold_cyc != '0) begin
            tmr <= hold_cyc - 1'b1;
        end else if (state == THR_HOLD && tmr != '0) begin
            tmr <= tmr - 1'b1;
        end
    end

    always_comb begin
        throttle = (state != THR_IDLE);
    end
endmodule

// File: rtl/oc_alarm_monitor.sv
module oc_alarm_monitor #(
    parameter int CNT_W       = 8,
    parameter int FILT_W      = 24,
    parameter int HOLD_W      = 16,
    parameter int CLK_PER_US  = 250,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alarm_raw,
    input  logic              cfg_active_low,
    input  logic              cfg_irq_en,
    input  logic [CNT_W-1:0]  cfg_threshold,
    input  logic [FILT_W-1:0] cfg_filter,
    input  logic [HOLD_W-1:0] cfg_hold_us,
    output logic              throttle_o,
    output logic              irq_o
);
    logic alarm_lvl;
    logic alarm_evt;

    oc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw        (alarm_raw),
        .active_low (cfg_active_low),
        .lvl        (alarm_lvl),
        .evt        (alarm_evt)
    );

    oc_event_counter #(.CNT_W(CNT_W), .FILT_W(FILT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (alarm_evt),
        .irq_en    (cfg_irq_en),
        .threshold (cfg_threshold),
        .filter    (cfg_filter),
        .irq       (irq_o)
    );

    oc_throttle_fsm #(.HOLD_W(HOLD_W), .CLK_PER_US(CLK_PER_US)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (alarm_lvl),
        .hold_us  (cfg_hold_us),
        .throttle (throttle_o)
    );
endmodule

// File: rtl/oc_alarm_monitor_chk.sv
module oc_alarm_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_irq_en,
    input logic alarm_lvl,
    input logic alarm_evt,
    input logic throttle_o,
    input logic irq_o
);
    // R10: outputs quiet during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r10_reset_quiet: assert (!throttle_o && !irq_o);
        end
    end

    // R2: a seen alarm level always yields throttle next cycle
    a_r2_level_throttles: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_lvl |=> throttle_o);

    // R3: interrupt is a single-cycle pulse
    a_r3_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R3: interrupt only follows a detected event
    a_r3_irq_after_event: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(alarm_evt));

    // R5: disabled interrupts stay silent
    a_r5_irq_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_irq_en |=> !irq_o);

    // R8: throttle never releases while the alarm level was present
    a_r8_release_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(throttle_o) |-> !$past(alarm_lvl));
endmodule

bind oc_alarm_monitor oc_alarm_monitor_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_irq_en (cfg_irq_en),
    .alarm_lvl  (alarm_lvl),
    .alarm_evt  (alarm_evt),
    .throttle_o (throttle_o),
    .irq_o      (irq_o)
);

// File: tb/oc_alarm_monitor_test.sv
`timescale 1ns/1ps
module oc_alarm_monitor_test;
    localparam int CNT_W = 8, FILT_W = 24, HOLD_W = 16, CPU = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alarm_raw = 1'b0;
    logic cfg_active_low = 1'b0;
    logic cfg_irq_en = 1'b1;
    logic [CNT_W-1:0]  cfg_threshold = 8'd3;
    logic [FILT_W-1:0] cfg_filter = '0;
    logic [HOLD_W-1:0] cfg_hold_us = '0;
    logic throttle_o, irq_o;

    always #2 clk = ~clk;   // 250 MHz

    oc_alarm_monitor #(.CNT_W(CNT_W), .FILT_W(FILT_W), .HOLD_W(HOLD_W),
                       .CLK_PER_US(CPU)) uut (
        .clk(clk), .rst_n(rst_n), .alarm_raw(alarm_raw),
        .cfg_active_low(cfg_active_low), .cfg_irq_en(cfg_irq_en),
        .cfg_threshold(cfg_threshold), .cfg_filter(cfg_filter),
        .cfg_hold_us(cfg_hold_us), .throttle_o(throttle_o), .irq_o(irq_o));

    int checks = 0, fails = 0;
    string cur_req = "R10";
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    bit q[$];
    bit m_prev, m_active, m_irq;
    int m_count, m_idle, m_hold;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q = {1'b0, 1'b0};
            m_prev = 0; m_active = 0; m_irq = 0;
            m_count = 0; m_idle = 0; m_hold = 0;
        end else begin
            bit lv, ev;
            int thr;
            lv = q[0];
            ev = lv && !m_prev;
            thr = (cfg_threshold == 0) ? 1 : int'(cfg_threshold);
            m_irq = 0;
            if (ev) begin
                m_idle = 0;
                if (m_count + 1 >= thr) begin
                    m_count = 0;
                    m_irq = cfg_irq_en;
                end else m_count++;
            end else if (cfg_filter != 0) begin
                if (m_idle + 1 >= int'(cfg_filter)) begin
                    m_count = 0; m_idle = 0;
                end else m_idle++;
            end
            if (lv) begin
                m_active = 1; m_hold = 0;
            end else if (m_active) begin
                m_active = 0; m_hold = int'(cfg_hold_us) * CPU;
            end else if (m_hold > 0) m_hold--;
            m_prev = lv;
            void'(q.pop_front());
            q.push_back(alarm_raw ^ cfg_active_low);
        end
    end

    int irq_seen, thr_cycles, thr_falls;
    bit last_thr;
    always @(negedge clk) begin
        if (!finished) begin
            bit e_thr;
            e_thr = m_active || (m_hold > 0);
            chk(throttle_o == e_thr, cur_req, throttle_o, e_thr);
            chk(irq_o == m_irq, cur_req, irq_o, m_irq);
            if (irq_o) irq_seen++;
            if (throttle_o) thr_cycles++;
            if (last_thr && !throttle_o) thr_falls++;
            last_thr = throttle_o;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(input int hi, input int lo);
        alarm_raw = ~cfg_active_low; step(hi);
        alarm_raw = cfg_active_low;  step(lo);
    endtask

    task automatic clr();
        irq_seen = 0; thr_cycles = 0; thr_falls = 0;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        step(4);
        cur_req = "R10";
        chk(throttle_o == 0, "R10", throttle_o, 0);
        chk(irq_o == 0, "R10", irq_o, 0);
        rst_n = 1'b1; step(3);

        // R3: threshold 3, six events -> two pulses
        cur_req = "R3"; clr();
        for (int i = 0; i < 6; i++) pulse(3, 3);
        step(10);
        chk(irq_seen == 2, "R3", irq_seen, 2);

        // R4: threshold 0 and 1 -> every event
        cur_req = "R4"; cfg_threshold = 0; clr();
        for (int i = 0; i < 4; i++) pulse(2, 2);
        step(6);
        chk(irq_seen == 4, "R4", irq_seen, 4);
        cfg_threshold = 1; clr();
        for (int i = 0; i < 3; i++) pulse(2, 2);
        step(6);
        chk(irq_seen == 3, "R4", irq_seen, 3);

        // R5: interrupts disabled, throttling continues
        cur_req = "R5"; cfg_irq_en = 0; cfg_threshold = 0; clr();
        for (int i = 0; i < 3; i++) pulse(4, 3);
        step(6);
        chk(irq_seen == 0, "R5", irq_seen, 0);
        chk(thr_cycles == 12, "R5", thr_cycles, 12);
        cfg_irq_en = 1;

        // R6: filter clears a partial count after inactivity
        cur_req = "R6"; cfg_threshold = 3; cfg_filter = 20; clr();
        pulse(3, 3); pulse(3, 3);
        step(40);
        pulse(3, 3); pulse(3, 3);
        step(6);
        chk(irq_seen == 0, "R6", irq_seen, 0);
        pulse(3, 3); step(6);
        chk(irq_seen == 1, "R6", irq_seen, 1);

        // R7: filter 0 never clears
        cur_req = "R7"; cfg_filter = 0; clr();
        pulse(3, 3); pulse(3, 3);
        step(100);
        pulse(3, 3); step(6);
        chk(irq_seen == 1, "R7", irq_seen, 1);

        // R8 / R2: hold after deassertion
        cur_req = "R8"; cfg_threshold = 8'd255; cfg_hold_us = 3; clr();
        pulse(5, 30);
        chk(thr_cycles == 5 + 3 * CPU, "R8", thr_cycles, 5 + 3 * CPU);
        cfg_hold_us = 0; clr();
        cur_req = "R2";
        pulse(5, 10);
        chk(thr_cycles == 5, "R2", thr_cycles, 5);

        // R9: re-alarm during hold keeps throttle continuous
        cur_req = "R9"; cfg_hold_us = 3; clr();
        pulse(5, 6); pulse(5, 30);
        chk(thr_falls == 1, "R9", thr_falls, 1);
        chk(thr_cycles == 28, "R9", thr_cycles, 28);

        // R1: active-low polarity
        cur_req = "R1"; cfg_hold_us = 0; cfg_threshold = 0;
        cfg_active_low = 1; alarm_raw = 1; step(6); clr();
        step(20);
        chk(thr_cycles == 0, "R1", thr_cycles, 0);
        pulse(4, 5); pulse(4, 5);
        chk(thr_cycles == 8, "R1", thr_cycles, 8);
        chk(irq_seen == 2, "R1", irq_seen, 2);

        step(5);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule